// File: doc/BRIEF.md
# Memory Bus Arbiter with Data-Cycle Booking

This block shares one address bus and one 72-bit data bus among seven memory clients: instruction fetch, data access, a slow-channel multiplexer, a fast channel, and three special data-access units. Eight memory banks sit behind the buses. Banks 0 to 5 are slow. Banks 6 and 7 are fast. A bank takes its address on the address bus. After a fixed delay that depends on its speed class, it uses the data bus for exactly one cycle.

Every cycle, each client may present a request, a 3-bit target bank and an urgency flag. A channel client raises the urgency flag when its buffer is close to overrun or underrun. A client can compete only if two conditions hold: its target bank will be idle by the next cycle, and the data-bus cycle that bank will need is still unbooked. Among the competing clients, the winner is registered onto the address bus for the following cycle. The arbiter then books the winner's future data-bus cycle and starts the bank's occupancy timer.

The block holds no memory storage and no ECC. It models them with per-bank busy timers and a shifting ring of data-cycle bookings. The bank index selects the timing, so the data-bus cycle and the busy time of each grant follow from the index alone.

Top module: `mem_bus_arbiter`

## Requirements
- R1: While reset is asserted, and on the first cycle after reset is released, no grant, no data ownership and no busy bank are shown.
- R2: A request is answered one cycle later, at the earliest. On that cycle `grant_o` is one-hot, bit c stands for client c, `addr_valid_o` is high, and `addr_bank_o` equals the bank that client requested.
- R3: For a slow bank (index 0 to 5), `data_grant_o` shows the granted client, and `data_valid_o` is high, exactly 5 cycles after the address cycle.
- R4: For a fast bank (index 6 or 7), the data cycle comes exactly 4 cycles after the address cycle.
- R5: A slow bank shows busy for 7 cycles, starting with its address cycle. No new address cycle goes to that bank until 7 cycles have passed.
- R6: A fast bank is busy for 4 cycles, starting with its address cycle. It reads as idle from the 5th cycle onward when no one requests it again.
- R7: A request whose data cycle is already booked is held off, even when its bank is idle. It is granted on the first cycle whose data slot is free.
- R8: An eligible urgent client wins over any eligible non-urgent client, whatever their indices.
- R9: Among eligible clients at the same urgency level, the lowest client index wins. The others are granted on later cycles.
- R10: With no requests present, no address grant is issued and no data cycle appears that was not booked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 7 | Request bit per client |
| bank_i | input | 21 | Target bank per client, 3 bits each, client c at bits [3c+2:3c] |
| urgent_i | input | 7 | Urgency level per client (1 = high) |
| grant_o | output | 7 | One-hot owner of the address bus this cycle |
| addr_valid_o | output | 1 | Address bus in use this cycle |
| addr_bank_o | output | 3 | Bank addressed this cycle |
| data_valid_o | output | 1 | Data bus booked for this cycle |
| data_grant_o | output | 7 | One-hot owner of the data bus this cycle |
| bank_busy_o | output | 8 | Bank occupied this cycle |

## Verification
Two kinds of event can land in the same cycle: an address grant for one client, and the data cycle of an earlier grant for another client. Which of them wins depends on the data slot that is already booked. The bench provokes a clash on purpose. It grants a slow bank and then, on the next cycle, asks for a fast bank whose data cycle would fall on the very same slot. It then expects the fast request to slip by one cycle. A scoreboard predicts every data-bus owner from the bank class at the moment each grant is checked. A monitor compares that prediction with `data_grant_o` on every cycle, so a misplaced or double-booked data cycle shows up even while the next address grants are being exercised.

// File: rtl/mba_pkg.sv
package mba_pkg;
    localparam int DEF_CLIENTS    = 7;
    localparam int DEF_BANKS      = 8;
    localparam int DEF_SLOW_BANKS = 6;
    localparam int DEF_SLOW_LAT   = 5;
    localparam int DEF_FAST_LAT   = 4;
    localparam int DEF_SLOW_BUSY  = 7;
    localparam int DEF_FAST_BUSY  = 4;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/mba_eligible.sv
module mba_eligible #(
    parameter int NUM_BANKS  = 8,
    parameter int SLOW_BANKS = 6,
    parameter int SLOW_LAT   = 5,
    parameter int FAST_LAT   = 4,
    parameter int CNT_W      = 3,
    parameter int RING_DEPTH = 7,
    localparam int BANK_W    = $clog2(NUM_BANKS)
) (
    input  logic                       want,
    input  logic [BANK_W-1:0]          target,
    input  logic [NUM_BANKS*CNT_W-1:0] bank_cnt,
    input  logic [RING_DEPTH-1:0]      slot_taken,
    output logic                       eligible
);
    logic [CNT_W-1:0] cnt_sel;
    logic             is_slow;
    logic             slot_busy;

    always_comb begin
        cnt_sel   = bank_cnt[target*CNT_W +: CNT_W];
        is_slow   = (target < BANK_W'(SLOW_BANKS));
        // The address cycle is one cycle ahead, so the slot sits at latency + 1.
        slot_busy = is_slow ? slot_taken[SLOW_LAT+1] : slot_taken[FAST_LAT+1];
        eligible  = want && (cnt_sel <= CNT_W'(1)) && !slot_busy;
    end
endmodule

// File: rtl/mba_pick.sv
module mba_pick #(
    parameter int N = 7
) (
    input  logic [N-1:0] elig,
    input  logic [N-1:0] urgent,
    output logic [N-1:0] win
);
    logic [N-1:0] hot;
    logic [N-1:0] pool;

    always_comb begin
        hot  = elig & urgent;
        pool = (|hot) ? hot : elig;
        win  = pool & (~pool + N'(1));
    end
endmodule

// File: rtl/mem_bus_arbiter.sv
module mem_bus_arbiter
    import mba_pkg::*;
#(
    parameter int NUM_CLIENTS = DEF_CLIENTS,
    parameter int NUM_BANKS   = DEF_BANKS,
    parameter int SLOW_BANKS  = DEF_SLOW_BANKS,
    parameter int SLOW_LAT    = DEF_SLOW_LAT,
    parameter int FAST_LAT    = DEF_FAST_LAT,
    parameter int SLOW_BUSY   = DEF_SLOW_BUSY,
    parameter int FAST_BUSY   = DEF_FAST_BUSY,
    localparam int BANK_W     = $clog2(NUM_BANKS),
    localparam int CNT_W      = $clog2(max2(SLOW_BUSY, FAST_BUSY) + 1),
    localparam int RING_DEPTH = max2(SLOW_LAT, FAST_LAT) + 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_CLIENTS-1:0]        req_i,
    input  logic [NUM_CLIENTS*BANK_W-1:0] bank_i,
    input  logic [NUM_CLIENTS-1:0]        urgent_i,
    output logic [NUM_CLIENTS-1:0]        grant_o,
    output logic                          addr_valid_o,
    output logic [BANK_W-1:0]             addr_bank_o,
    output logic                          data_valid_o,
    output logic [NUM_CLIENTS-1:0]        data_grant_o,
    output logic [NUM_BANKS-1:0]          bank_busy_o
);
    typedef struct packed {
        logic [NUM_CLIENTS-1:0]                 grant;
        logic [BANK_W-1:0]                      abank;
        logic [NUM_BANKS-1:0][CNT_W-1:0]        cnt;
        logic [RING_DEPTH-1:0][NUM_CLIENTS-1:0] slot;
    } state_t;

    state_t st_q, st_d;

    logic [NUM_BANKS*CNT_W-1:0] cnt_flat;
    logic [RING_DEPTH-1:0]      taken;
    logic [NUM_CLIENTS-1:0]     elig;
    logic [NUM_CLIENTS-1:0]     win;

    always_comb begin
        cnt_flat = st_q.cnt;
        for (int k = 0; k < RING_DEPTH; k++) begin
            taken[k] = |st_q.slot[k];
        end
    end

    for (genvar c = 0; c < NUM_CLIENTS; c++) begin : g_client
        mba_eligible #(
            .NUM_BANKS (NUM_BANKS),
            .SLOW_BANKS(SLOW_BANKS),
            .SLOW_LAT  (SLOW_LAT),
            .FAST_LAT  (FAST_LAT),
            .CNT_W     (CNT_W),
            .RING_DEPTH(RING_DEPTH)
        ) u_elig (
            .want      (req_i[c]),
            .target    (bank_i[c*BANK_W +: BANK_W]),
            .bank_cnt  (cnt_flat),
            .slot_taken(taken),
            .eligible  (elig[c])
        );
    end

    mba_pick #(.N(NUM_CLIENTS)) u_pick (
        .elig  (elig),
        .urgent(urgent_i),
        .win   (win)
    );

    always_comb begin
        st_d       = st_q;
        st_d.grant = win;
        st_d.abank = '0;
        for (int c = 0; c < NUM_CLIENTS; c++) begin
            if (win[c]) begin
                st_d.abank = bank_i[c*BANK_W +: BANK_W];
            end
        end
        for (int b = 0; b < NUM_BANKS; b++) begin
            st_d.cnt[b] = (st_q.cnt[b] != '0) ? st_q.cnt[b] - CNT_W'(1) : '0;
        end
        for (int k = 0; k < RING_DEPTH - 1; k++) begin
            st_d.slot[k] = st_q.slot[k+1];
        end
        st_d.slot[RING_DEPTH-1] = '0;
        if (|win) begin
            if (st_d.abank < BANK_W'(SLOW_BANKS)) begin
                st_d.cnt[st_d.abank] = CNT_W'(SLOW_BUSY);
                st_d.slot[SLOW_LAT]  = win;
            end else begin
                st_d.cnt[st_d.abank] = CNT_W'(FAST_BUSY);
                st_d.slot[FAST_LAT]  = win;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        grant_o      = st_q.grant;
        addr_valid_o = |st_q.grant;
        addr_bank_o  = st_q.abank;
        data_grant_o = st_q.slot[0];
        data_valid_o = |st_q.slot[0];
        for (int b = 0; b < NUM_BANKS; b++) begin
            bank_busy_o[b] = (st_q.cnt[b] != '0);
        end
    end

    assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));

    assert_grant_requested_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o != '0) |-> ((grant_o & ~$past(req_i)) == '0));

    assert_data_owner_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(data_grant_o) && (data_valid_o == (data_grant_o != '0)));

    assert_bank_busy_on_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid_o |-> bank_busy_o[addr_bank_o]);

    assert_no_back_to_back_R6: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid_o |=> !(addr_valid_o && (addr_bank_o == $past(addr_bank_o))));

    assert_quiet_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i == '0) |=> (grant_o == '0));
endmodule

// File: tb/mem_bus_arbiter_tb.sv
module mem_bus_arbiter_tb;
    localparam int NC = 7;
    localparam int NB = 8;
    localparam int BW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NC-1:0] req;
    logic [NC-1:0] urgent;
    logic [NC*BW-1:0] bank;
    logic [NC-1:0] grant;
    logic          addr_valid;
    logic [BW-1:0] addr_bank;
    logic          data_valid;
    logic [NC-1:0] data_grant;
    logic [NB-1:0] bank_busy;

    always #4 clk = ~clk;

    mem_bus_arbiter u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req),
        .bank_i      (bank),
        .urgent_i    (urgent),
        .grant_o     (grant),
        .addr_valid_o(addr_valid),
        .addr_bank_o (addr_bank),
        .data_valid_o(data_valid),
        .data_grant_o(data_grant),
        .bank_busy_o (bank_busy)
    );

    typedef struct {
        int            at;
        logic [NC-1:0] mask;
        string         tag;
    } item_t;

    item_t sb[$];
    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Monitor: pops the booked data cycles and compares every cycle.
    logic [NC-1:0] mon_exp;
    string         mon_tag;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            mon_exp = '0;
            mon_tag = "R10";
            if (sb.size() > 0 && sb[0].at == cyc) begin
                mon_exp = sb[0].mask;
                mon_tag = sb[0].tag;
                void'(sb.pop_front());
            end
            check(mon_tag, int'(data_grant), int'(mon_exp));
            check(mon_tag, int'(data_valid), int'(mon_exp != '0));
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic ask(int c, int b, bit u);
        req[c]            = 1'b1;
        bank[c*BW +: BW]  = BW'(b);
        urgent[c]         = u;
    endtask

    task automatic drop(int c);
        req[c]    = 1'b0;
        urgent[c] = 1'b0;
    endtask

    // Driver side of the scoreboard: checks the address grant, books the data cycle.
    task automatic expect_grant(int c, int b, string tag);
        logic [NC-1:0] exp;
        exp = (c < 0) ? '0 : NC'(1) << c;
        check(tag, int'(grant), int'(exp));
        if (c >= 0) begin
            check(tag, int'(addr_bank), b);
            check(tag, int'(addr_valid), 1);
            sb.push_back('{cyc + ((b < 6) ? 5 : 4), exp, (b < 6) ? "R3" : "R4"});
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            tick();
            expect_grant(-1, 0, "R10");
        end
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL R10 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        req = '0;
        urgent = '0;
        bank = '0;
        repeat (3) tick();
        check("R1", int'(grant), 0);
        check("R1", int'(data_valid), 0);
        check("R1", int'(bank_busy), 0);
        rst_n = 1'b1;
        tick();
        check("R1", int'(grant), 0);
        check("R1", int'(addr_valid), 0);
        check("R1", int'(bank_busy), 0);

        // R2, R3, R5: slow bank grant, then a second client waits out the busy time.
        ask(0, 0, 1'b0);
        tick();
        expect_grant(0, 0, "R2");
        drop(0);
        check("R5", int'(bank_busy[0]), 1);
        ask(1, 0, 1'b0);
        for (int k = 1; k <= 6; k++) begin
            tick();
            expect_grant(-1, 0, "R5");
            check("R5", int'(bank_busy[0]), 1);
        end
        tick();
        expect_grant(1, 0, "R5");
        drop(1);
        idle(10);

        // R4, R6: fast bank timing.
        ask(2, 6, 1'b0);
        tick();
        expect_grant(2, 6, "R4");
        drop(2);
        ask(3, 6, 1'b0);
        for (int k = 1; k <= 3; k++) begin
            tick();
            expect_grant(-1, 0, "R6");
        end
        tick();
        expect_grant(3, 6, "R6");
        drop(3);
        repeat (3) tick();
        check("R6", int'(bank_busy[6]), 1);
        tick();
        check("R6", int'(bank_busy[6]), 0);
        idle(8);

        // R7: address grant clashes with an already booked data cycle.
        ask(0, 1, 1'b0);
        tick();
        expect_grant(0, 1, "R7");
        drop(0);
        ask(1, 7, 1'b0);
        tick();
        expect_grant(-1, 0, "R7");
        tick();
        expect_grant(1, 7, "R7");
        drop(1);
        idle(10);

        // R8: urgency beats index.
        ask(0, 2, 1'b0);
        ask(4, 3, 1'b1);
        tick();
        expect_grant(4, 3, "R8");
        drop(4);
        tick();
        expect_grant(0, 2, "R8");
        drop(0);
        idle(10);

        // R9: same level, low index first (normal level, slow banks).
        ask(5, 4, 1'b0);
        ask(2, 5, 1'b0);
        tick();
        expect_grant(2, 5, "R9");
        drop(2);
        tick();
        expect_grant(5, 4, "R9");
        drop(5);
        idle(10);

        // R9: same level, low index first (urgent level, fast banks).
        ask(6, 6, 1'b1);
        ask(3, 7, 1'b1);
        tick();
        expect_grant(3, 7, "R9");
        drop(3);
        tick();
        expect_grant(6, 6, "R9");
        drop(6);
        idle(12);

        check("R10", int'(bank_busy), 0);
        check("R3", sb.size(), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule